// File: doc/BRIEF.md
# Dual-Mode Clock Switch

This block picks one of two free-running input clocks and places it on a single output clock net. A select input chooses the source. A mode input chooses how a change of source is carried out. In the asynchronous mode the block is a plain combinational multiplexer. The output then follows the chosen input at once, and this works even when the other input, or both inputs, are stopped. In the glitch-free mode each source has its own enable, held in that clock's domain. A change of source hands over from one enable to the other through synchronizers, so no shortened high or low phase can reach the output.

The intended use starts the block in the asynchronous mode. This gives a usable clock while one source may still be absent. Once both sources run, the mode input is raised and the block switches glitch-free from then on, with no reset needed. Each source leg is a small two-state machine (`LEG_OFF`, `LEG_ON`), clocked on the falling edge of its own clock. Its transitions are:

- `OFF->ON`, taken when the synchronized request is seen high.
- `ON->OFF`, taken when the synchronized request is seen low.

The request of a leg is high only while the leg is selected and the other leg is fully idle. The other leg is idle when its synchronizer and its state are both clear.

Top module: `dual_mode_clk_switch`

## Requirements
- R1: When `sel_a` is 1 the output carries `clk_a`. When `sel_a` is 0 it carries `clk_b`. This holds in both modes once a change has settled.
- R2: When `gf_mode` is 0 (asynchronous mode), the output is the selected input through combinational logic only. It follows that input even when the other input is stopped. If the selected input is stopped, the output holds that input's static level.
- R3: The two source enables are never on at the same time.
- R4: In glitch-free mode, after a select change the old enable turns off on the third falling edge of the old clock: two synchronizer stages, then the state register. The new enable turns on only after that, on the third falling edge of the new clock after the old leg has gone idle.
- R5: While glitch-free mode is active and both enables are off, the output is low. No output high or low phase is shorter than the shorter half-period of the two inputs.
- R6: In glitch-free mode, a switch to a stopped clock leaves the output low. The switch completes once that clock starts running.
- R7: Changing `gf_mode` from 1 to 0 takes effect at once. The output becomes the combinational selection, even in the middle of a hand-over.
- R8: The block can come out of reset in asynchronous mode with one clock missing, and later enter glitch-free mode without a reset. It keeps its selection, and the output shows no short pulse.
- R9: An active-low asynchronous `rst_n` clears both enables. In glitch-free mode the output is low during reset. After release, the selected path is set up again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Source clock A |
| clk_b | input | 1 | Source clock B |
| rst_n | input | 1 | Asynchronous active-low reset of both source legs |
| sel_a | input | 1 | Source select: 1 picks A, 0 picks B |
| gf_mode | input | 1 | Switching mode: 0 asynchronous, 1 glitch-free |
| clk_out | output | 1 | Selected output clock |

## Verification
The main function is driven with alternating selections in each mode, with both inputs running at unrelated periods of 20 ns and 34 ns. Because the two periods differ, counting output rising edges over a fixed window shows which source is actually on the net. A pulse-width monitor flags any output phase below half the faster period, which separates a true glitch-free hand-over from a raw mux change. Further patterns stop one or both inputs. These show the asynchronous mode working without the other clock, the glitch-free mode parking low on a dead target, and the immediate fall-back to asynchronous mode. A select change timed to a known edge of clock A pins down the hand-over latency of R4.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    typedef enum logic {
        LEG_OFF = 1'b0,
        LEG_ON  = 1'b1
    } leg_state_e;

    localparam int NUM_SRC = 2;
endpackage

// File: rtl/clksw_leg.sv
module clksw_leg
    import clksw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic en,
    output logic busy
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         sync_out;
    leg_state_e   st_q;
    leg_state_e   st_d;

    // request synchronizer on the falling edge of this leg's clock
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[TOP-1:0], req};
    end

    assign sync_out = sync_q[TOP];

    // state register
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LEG_OFF;
        else        st_q <= st_d;
    end

    // next-state and outputs
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LEG_OFF: if (sync_out)  st_d = LEG_ON;
            LEG_ON:  if (!sync_out) st_d = LEG_OFF;
        endcase
    end

    always_comb begin
        en   = (st_q == LEG_ON);
        busy = en | (|sync_q);
    end

    // R4: an enable rises only after the synchronized request was high
    p_on_after_sync_r4: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(sync_out));

    // R4: a low synchronized request drops the enable on the next falling edge
    p_off_after_sync_r4: assert property (@(negedge clk) disable iff (!rst_n)
        (en && !sync_out) |=> !en);
endmodule

// File: rtl/clksw_outmux.sv
module clksw_outmux (
    input  logic       clk_a,
    input  logic       clk_b,
    input  logic       sel_a,
    input  logic       gf_mode,
    input  logic [1:0] en,
    output logic       clk_out
);
    always_comb begin
        if (gf_mode) clk_out = (clk_a & en[0]) | (clk_b & en[1]);
        else         clk_out = sel_a ? clk_a : clk_b;
    end
endmodule

// File: rtl/dual_mode_clk_switch.sv
module dual_mode_clk_switch
    import clksw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel_a,
    input  logic gf_mode,
    output logic clk_out
);
    logic [NUM_SRC-1:0] clk_v;
    logic [NUM_SRC-1:0] want;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] busy;

    assign clk_v = {clk_b, clk_a};
    assign want  = {~sel_a, sel_a};

    // a leg may ask for its clock only when the other leg is fully idle
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_leg
            assign req[g] = want[g] & ~busy[NUM_SRC-1-g];

            clksw_leg #(.SYNC_STAGES(SYNC_STAGES)) u_leg (
                .clk  (clk_v[g]),
                .rst_n(rst_n),
                .req  (req[g]),
                .en   (en[g]),
                .busy (busy[g])
            );
        end
    endgenerate

    clksw_outmux u_mux (
        .clk_a  (clk_a),
        .clk_b  (clk_b),
        .sel_a  (sel_a),
        .gf_mode(gf_mode),
        .en     (en),
        .clk_out(clk_out)
    );

    // R3: enables exclusive, seen from either clock
    p_excl_a_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(en[0] && en[1]));
    p_excl_b_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(en[0] && en[1]));

    // R5: output parked low while no leg is enabled in glitch-free mode
    p_gap_low_a_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
        (gf_mode && en == '0) |-> !clk_out);
    p_gap_low_b_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
        (gf_mode && en == '0) |-> !clk_out);
endmodule

// File: tb/dual_mode_clk_switch_tb.sv
`timescale 1ns/1ps
module dual_mode_clk_switch_tb;
    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic run_a = 1'b1;
    logic run_b = 1'b1;
    logic rst_n = 1'b0;
    logic sel_a = 1'b1;
    logic gf_mode = 1'b1;
    logic clk_out;

    int checks = 0;
    int failures = 0;
    int cnt_out = 0, cnt_a = 0, cnt_b = 0;
    int viol = 0;
    bit mon_en = 1'b0;
    bit have_last = 1'b0;
    realtime last_t = 0;
    bit done = 1'b0;

    localparam int EXP_A = 0, EXP_B = 1, EXP_NONE = 2;
    localparam realtime MIN_PHASE = 9.5;

    // clk_a doubles as the 50 MHz bench clock
    always begin #10; clk_a = run_a ? ~clk_a : 1'b0; end
    always begin #17; clk_b = run_b ? ~clk_b : 1'b0; end

    dual_mode_clk_switch u_dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .sel_a(sel_a), .gf_mode(gf_mode), .clk_out(clk_out)
    );

    always @(posedge clk_out) cnt_out++;
    always @(posedge clk_a)   cnt_a++;
    always @(posedge clk_b)   cnt_b++;

    always @(clk_out) begin
        if (mon_en && have_last && ($realtime - last_t) < MIN_PHASE) viol++;
        last_t = $realtime;
        have_last = mon_en;
    end
    always @(negedge mon_en) have_last = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic window(input int exp, input string req);
        int o0 = cnt_out, a0 = cnt_a, b0 = cnt_b;
        int d, e;
        #400;
        d = cnt_out - o0;
        e = (exp == EXP_A) ? cnt_a - a0 : (exp == EXP_B) ? cnt_b - b0 : 0;
        if (exp == EXP_NONE) check(d == 0, req, d, 0);
        else                 check(d >= e - 1 && d <= e + 1, req, d, e);
    endtask

    task automatic apply(input bit gf, input bit sel, input int exp);
        int v0;
        if (!gf || !gf_mode) mon_en = 1'b0;
        gf_mode = gf;
        sel_a = sel;
        #600;
        mon_en = 1'b1;
        v0 = viol;
        window(exp, gf ? "R1" : "R2");
        if (gf) check(viol == v0, "R5", viol - v0, 0);
    endtask

    // {gf_mode, sel_a, expected source[1:0]}
    localparam logic [3:0] STEPS [9] = '{
        {1'b1, 1'b1, 2'd0}, {1'b1, 1'b0, 2'd1}, {1'b1, 1'b1, 2'd0},
        {1'b0, 1'b1, 2'd0}, {1'b0, 1'b0, 2'd1}, {1'b0, 1'b1, 2'd0},
        {1'b1, 1'b1, 2'd0}, {1'b1, 1'b0, 2'd1}, {1'b0, 1'b0, 2'd1}
    };

    initial begin
        int v0, o0;
        // R9: reset in glitch-free mode keeps the output low
        #50;
        window(EXP_NONE, "R9");
        rst_n = 1'b1;
        #600;
        mon_en = 1'b1;

        for (int i = 0; i < 9; i++)
            apply(STEPS[i][3], STEPS[i][2], int'(STEPS[i][1:0]));

        // R4: hand-over timing from A to B
        apply(1'b1, 1'b1, EXP_A);
        @(posedge clk_a); #1;
        sel_a = 1'b0;
        o0 = cnt_out; #44;
        check(cnt_out - o0 == 2, "R4", cnt_out - o0, 2);
        o0 = cnt_out; #68;
        check(cnt_out - o0 == 0, "R4", cnt_out - o0, 0);
        #500;
        window(EXP_B, "R4");

        // R6: glitch-free switch to a stopped clock parks low
        apply(1'b1, 1'b1, EXP_A);
        run_b = 1'b0;
        #100;
        v0 = viol;
        sel_a = 1'b0;
        #600;
        window(EXP_NONE, "R6");
        check(viol == v0, "R5", viol - v0, 0);
        run_b = 1'b1;
        #600;
        window(EXP_B, "R6");

        // R7: falling back to asynchronous mode is immediate
        run_b = 1'b0;
        #100;
        mon_en = 1'b0;
        gf_mode = 1'b0;
        sel_a = 1'b1;
        o0 = cnt_out; #100;
        check(cnt_out - o0 >= 4, "R7", cnt_out - o0, 5);
        run_b = 1'b1;

        // R2: asynchronous mode with stopped inputs
        run_b = 1'b0;
        #200;
        window(EXP_A, "R2");
        sel_a = 1'b0;
        #100;
        window(EXP_NONE, "R2");
        run_a = 1'b0;
        sel_a = 1'b1;
        #100;
        window(EXP_NONE, "R2");
        run_a = 1'b1;

        // R8: power-up async with B missing, then glitch-free without reset
        rst_n = 1'b0;
        #100;
        rst_n = 1'b1;
        #300;
        window(EXP_A, "R8");
        run_b = 1'b1;
        #200;
        mon_en = 1'b1;
        #100;
        v0 = viol;
        gf_mode = 1'b1;
        #600;
        window(EXP_A, "R8");
        check(viol == v0, "R8", viol - v0, 0);

        // R9: reset clears enables, then the path comes back
        rst_n = 1'b0;
        #50;
        window(EXP_NONE, "R9");
        rst_n = 1'b1;
        #600;
        window(EXP_A, "R9");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule